// File: doc/BRIEF.md
# Idle Mode Power Controller

This block puts a small 8-bit microcontroller core into a low-power idle state and brings it back out. Software sets bit 0 of an 8-bit power control register through a register write port. The instruction that performs the write is the last one clocked into the core. From the next falling edge of the oscillator, the core clock enable is held low. The clock enable for the interrupt, timer and serial logic stays high throughout. During idle the port pins are frozen at the value they had on entry, and both external bus strobes are forced high.

Idle ends in one of two ways. The first is an interrupt request that is both individually enabled and globally enabled; it clears bit 0 in hardware. The second is a reset pin held high long enough to qualify. The reset pin is synchronised to the oscillator. It counts as a reset only after `QUAL_CYC` consecutive high samples, which is 24 by default, or two machine cycles of twelve periods. A qualified reset drives `core_rst`, clears the register and restores the core clock. Bits 2 and 3 of the register are general-purpose flags owned by software. Software can mark in them whether it was idle when an interrupt arrived.

Top module: `idle_power_ctrl`

## Requirements
- R1: A write with `wr_data[0]`=1 while not idle sets `pcon_rd[0]` at the edge that captures it. `cpu_clk_en` falls at the next falling edge, and `cpu_clk` has no rising edge after the capturing edge until idle ends.
- R2: `periph_clk_en` stays high in idle and out of it.
- R3: While `pcon_rd[0]`=1, `port_pins` holds the `port_cpu` value seen at the entry edge, whatever `port_cpu` does afterwards; outside idle `port_pins` follows `port_cpu`.
- R4: While idle, `ale` and `psen` are 1; outside idle they follow `ale_cpu` and `psen_cpu`.
- R5: While idle, a clock edge with `irq_global_en`=1 and some bit set in both `irq_req` and `irq_en` clears `pcon_rd[0]`, and `cpu_clk_en` returns high at the following falling edge.
- R6: An interrupt request whose `irq_en` bit is 0, or any request while `irq_global_en`=0, leaves `pcon_rd[0]` at 1.
- R7: Register layout: bit 0 is idle, bit 2 is flag 0, bit 3 is flag 1, and the other bits read 0. A write loads bits 0, 2 and 3. Entering or leaving idle does not alter the flags.
- R8: `rst_pin` high for `QUAL_CYC` (24) consecutive oscillator periods asserts `core_rst`. This clears `pcon_rd` to 0 and restores `cpu_clk_en` to 1.
- R9: `rst_pin` high for fewer than `QUAL_CYC` consecutive periods never asserts `core_rst` and leaves the register and idle state unchanged.
- R10: While `arst_n` is low: `pcon_rd`=0, `cpu_clk_en`=1 and `core_rst`=0.
- R11: `cpu_clk_en` changes only while `clk` is low, so it is constant through every high phase of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| rst_pin | input | 1 | Active-high hardware reset pin, asynchronous |
| wr_en | input | 1 | Power control register write strobe |
| wr_data | input | 8 | Power control register write data |
| pcon_rd | output | 8 | Power control register contents |
| irq_req | input | IRQ_W | Interrupt request lines |
| irq_en | input | IRQ_W | Per-line interrupt enables |
| irq_global_en | input | 1 | Global interrupt enable |
| port_cpu | input | PORT_W | Port output value from the core |
| ale_cpu | input | 1 | Address latch strobe from the core |
| psen_cpu | input | 1 | Program store strobe from the core |
| port_pins | output | PORT_W | Port output value to the pins |
| ale | output | 1 | Address latch strobe to the pin |
| psen | output | 1 | Program store strobe to the pin |
| cpu_clk_en | output | 1 | Core clock enable, changes only while clk is low |
| cpu_clk | output | 1 | Gated core clock |
| periph_clk_en | output | 1 | Interrupt, timer and serial clock enable |
| core_rst | output | 1 | Qualified reset to the core |

## Verification
The bench holds the reset pin for exactly 23 periods and then for exactly 24. A qualifier that is off by one either resets the core on the short pulse or misses the qualifying one, and the register contents show which. It wakes the block with a request that is enabled only per line and with one that is enabled only globally. A design that ORs the wrong enables leaves idle too early. It also counts gated-clock rising edges after entry, where a late gate would leak an extra core cycle, and it changes `port_cpu` during idle to expose a hold register captured on the wrong edge. Finally, a write that sets idle arrives in the same cycle as an enabled request while the block is not yet idle. The write must win, and idle must end on the next edge.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int unsigned PCON_W    = 8;
  localparam int unsigned IDLE_BIT  = 0;
  localparam int unsigned FLAG0_BIT = 2;
  localparam int unsigned FLAG1_BIT = 3;
  localparam logic [PCON_W-1:0] PCON_WR_MASK =
    PCON_W'((1 << IDLE_BIT) | (1 << FLAG0_BIT) | (1 << FLAG1_BIT));
endpackage

// File: rtl/idle_rst_sync.sv
module idle_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/idle_rst_qual.sv
module idle_rst_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYC    = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic qualified
);
  localparam int unsigned CNT_W = $clog2(QUAL_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q, cnt_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  always_comb begin
    if (!sync_q[SYNC_STAGES-1])  cnt_d = '0;
    else if (cnt_q == CNT_MAX)   cnt_d = cnt_q;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign qualified = (cnt_q == CNT_MAX);
endmodule

// File: rtl/idle_pcon_reg.sv
module idle_pcon_reg
  import idle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PCON_W-1:0] wr_data,
  input  logic              wake,
  input  logic              core_rst,
  output logic [PCON_W-1:0] pcon_q,
  output logic              idle,
  output logic              enter
);
  logic [PCON_W-1:0] pcon_d;

  always_comb begin
    pcon_d = pcon_q;
    if (core_rst)                pcon_d = '0;
    else if (pcon_q[IDLE_BIT]) begin
      if (wake)                  pcon_d[IDLE_BIT] = 1'b0;
    end else if (wr_en)          pcon_d = wr_data & PCON_WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcon_q <= '0;
    else        pcon_q <= pcon_d;
  end

  assign idle  = pcon_q[IDLE_BIT];
  assign enter = !pcon_q[IDLE_BIT] && pcon_d[IDLE_BIT];
endmodule

// File: rtl/idle_clk_gate.sv
module idle_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic en,
  output logic gclk
);
  logic en_d;

  assign en_d = run;

  // Enable is updated on the falling edge, so it is constant across each high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b1;
    else        en <= en_d;
  end

  assign gclk = clk & en;
endmodule

// File: rtl/idle_io_hold.sv
module idle_io_hold #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              enter,
  input  logic [PORT_W-1:0] port_cpu,
  input  logic              ale_cpu,
  input  logic              psen_cpu,
  output logic [PORT_W-1:0] port_pins,
  output logic              ale,
  output logic              psen
);
  logic [PORT_W-1:0] hold_q, hold_d;

  assign hold_d = enter ? port_cpu : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign port_pins = idle ? hold_q : port_cpu;
  assign ale       = idle | ale_cpu;
  assign psen      = idle | psen_cpu;
endmodule

// File: rtl/idle_power_ctrl.sv
module idle_power_ctrl
  import idle_pkg::*;
#(
  parameter int unsigned IRQ_W       = 5,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYC    = 24
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              rst_pin,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        pcon_rd,
  input  logic [IRQ_W-1:0]  irq_req,
  input  logic [IRQ_W-1:0]  irq_en,
  input  logic              irq_global_en,
  input  logic [PORT_W-1:0] port_cpu,
  input  logic              ale_cpu,
  input  logic              psen_cpu,
  output logic [PORT_W-1:0] port_pins,
  output logic              ale,
  output logic              psen,
  output logic              cpu_clk_en,
  output logic              cpu_clk,
  output logic              periph_clk_en,
  output logic              core_rst
);
  logic rst_n_i;
  logic wake;
  logic idle;
  logic enter;

  assign wake          = irq_global_en && (|(irq_req & irq_en));
  assign periph_clk_en = 1'b1;

  idle_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n_i)
  );

  idle_rst_qual #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_CYC    (QUAL_CYC)
  ) u_rst_qual (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .pin       (rst_pin),
    .qualified (core_rst)
  );

  idle_pcon_reg u_pcon (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wake     (wake),
    .core_rst (core_rst),
    .pcon_q   (pcon_rd),
    .idle     (idle),
    .enter    (enter)
  );

  idle_clk_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n_i),
    .run   (!idle),
    .en    (cpu_clk_en),
    .gclk  (cpu_clk)
  );

  idle_io_hold #(
    .PORT_W (PORT_W)
  ) u_io (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .idle      (idle),
    .enter     (enter),
    .port_cpu  (port_cpu),
    .ale_cpu   (ale_cpu),
    .psen_cpu  (psen_cpu),
    .port_pins (port_pins),
    .ale       (ale),
    .psen      (psen)
  );
endmodule

// File: rtl/idle_power_ctrl_chk.sv
module idle_power_ctrl_chk #(
  parameter int unsigned IRQ_W  = 5,
  parameter int unsigned PORT_W = 8
) (
  input logic              clk,
  input logic              arst_n,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        pcon_rd,
  input logic [IRQ_W-1:0]  irq_req,
  input logic [IRQ_W-1:0]  irq_en,
  input logic              irq_global_en,
  input logic [PORT_W-1:0] port_pins,
  input logic              ale,
  input logic              psen,
  input logic              cpu_clk_en,
  input logic              core_rst
);
  logic en_at_rise_q;
  logic rise_seen_q;
  logic irq_live;

  assign irq_live = irq_global_en && (|(irq_req & irq_en));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      en_at_rise_q <= 1'b1;
      rise_seen_q  <= 1'b0;
    end else begin
      en_at_rise_q <= cpu_clk_en;
      rise_seen_q  <= 1'b1;
    end
  end

  a_r1_enter_idle: assert property (@(posedge clk) disable iff (!arst_n)
    (!pcon_rd[0] && wr_en && wr_data[0] && !core_rst) |=> pcon_rd[0]);

  a_r1_cpu_gated: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_clk_en == !pcon_rd[0]);

  a_r3_port_frozen: assert property (@(posedge clk) disable iff (!arst_n)
    (pcon_rd[0] && $past(pcon_rd[0])) |-> $stable(port_pins));

  a_r4_strobes_high: assert property (@(posedge clk) disable iff (!arst_n)
    pcon_rd[0] |-> (ale && psen));

  a_r5_wake_clears: assert property (@(posedge clk) disable iff (!arst_n)
    (pcon_rd[0] && !core_rst && irq_live) |=> !pcon_rd[0]);

  a_r6_no_false_wake: assert property (@(posedge clk) disable iff (!arst_n)
    (pcon_rd[0] && !core_rst && !irq_live) |=> pcon_rd[0]);

  a_r7_flags_kept: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_rst && !wr_en) |=> $stable(pcon_rd[3:2]));

  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!arst_n)
    core_rst |=> (pcon_rd == 8'h00));

  a_r11_glitch_free: assert property (@(negedge clk) disable iff (!arst_n)
    rise_seen_q |-> (cpu_clk_en == en_at_rise_q));
endmodule

bind idle_power_ctrl idle_power_ctrl_chk #(
  .IRQ_W  (IRQ_W),
  .PORT_W (PORT_W)
) u_chk (
  .clk           (clk),
  .arst_n        (arst_n),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .pcon_rd       (pcon_rd),
  .irq_req       (irq_req),
  .irq_en        (irq_en),
  .irq_global_en (irq_global_en),
  .port_pins     (port_pins),
  .ale           (ale),
  .psen          (psen),
  .cpu_clk_en    (cpu_clk_en),
  .core_rst      (core_rst)
);

// File: tb/idle_power_ctrl_bench.sv
module idle_power_ctrl_bench;
  localparam int CLK_P  = 10;
  localparam int IRQ_W  = 5;
  localparam int PORT_W = 8;
  localparam int NVEC   = 11;

  logic              clk = 1'b0;
  logic              arst_n, rst_pin, wr_en, irq_global_en, ale_cpu, psen_cpu;
  logic [7:0]        wr_data, pcon_rd;
  logic [IRQ_W-1:0]  irq_req, irq_en;
  logic [PORT_W-1:0] port_cpu, port_pins;
  logic              ale, psen, cpu_clk_en, cpu_clk, periph_clk_en, core_rst;

  int checks = 0;
  int fails  = 0;
  int gclk_edges = 0;
  int glitches = 0;
  bit rst_seen = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  idle_power_ctrl u_idle_power_ctrl (
    .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .wr_en(wr_en), .wr_data(wr_data),
    .pcon_rd(pcon_rd), .irq_req(irq_req), .irq_en(irq_en), .irq_global_en(irq_global_en),
    .port_cpu(port_cpu), .ale_cpu(ale_cpu), .psen_cpu(psen_cpu), .port_pins(port_pins),
    .ale(ale), .psen(psen), .cpu_clk_en(cpu_clk_en), .cpu_clk(cpu_clk),
    .periph_clk_en(periph_clk_en), .core_rst(core_rst)
  );

  always @(posedge cpu_clk) gclk_edges++;
  always @(negedge clk) if (core_rst === 1'b1) rst_seen = 1'b1;
  always @(posedge clk) begin : glitch_mon
    logic at_rise;
    #1 at_rise = cpu_clk_en;
    #(CLK_P/2 - 2) if (cpu_clk_en !== at_rise) glitches++;
  end

  // {wr_en, wr_data, irq_req, irq_en, gen, port_cpu, exp_pcon, exp_port}
  localparam logic [43:0] VECS [NVEC] = '{
    {1'b0, 8'h00, 5'h00, 5'h00, 1'b0, 8'hA5, 8'h00, 8'hA5}, // idle off, port passes
    {1'b1, 8'h0C, 5'h00, 5'h00, 1'b0, 8'h3C, 8'h0C, 8'h3C}, // R7 flags written
    {1'b1, 8'h0D, 5'h00, 5'h00, 1'b0, 8'h5A, 8'h0D, 8'h5A}, // R1 enter, R3 capture
    {1'b0, 8'h00, 5'h00, 5'h00, 1'b0, 8'hFF, 8'h0D, 8'h5A}, // R3 pins frozen
    {1'b0, 8'h00, 5'h01, 5'h00, 1'b1, 8'hFF, 8'h0D, 8'h5A}, // R6 line masked
    {1'b0, 8'h00, 5'h01, 5'h01, 1'b0, 8'hFF, 8'h0D, 8'h5A}, // R6 global off
    {1'b0, 8'h00, 5'h04, 5'h04, 1'b1, 8'h11, 8'h0C, 8'h11}, // R5 wake, R7 flags kept
    {1'b1, 8'hF1, 5'h00, 5'h00, 1'b0, 8'h22, 8'h01, 8'h22}, // R7 reserved read 0
    {1'b0, 8'h00, 5'h10, 5'h10, 1'b1, 8'h33, 8'h00, 8'h33}, // R5 top line wakes
    {1'b1, 8'h01, 5'h02, 5'h02, 1'b1, 8'h44, 8'h01, 8'h44}, // R1 write wins when not idle
    {1'b0, 8'h00, 5'h02, 5'h02, 1'b1, 8'h55, 8'h00, 8'h55}  // R5 wake next edge
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    arst_n = 1'b0; rst_pin = 1'b0; wr_en = 1'b0; wr_data = '0;
    irq_req = '0; irq_en = '0; irq_global_en = 1'b0;
    port_cpu = '0; ale_cpu = 1'b0; psen_cpu = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk("R10 pcon", 16'(pcon_rd), 16'h00);
    chk("R10 cpu_clk_en", 16'(cpu_clk_en), 16'h1);
    chk("R10 core_rst", 16'(core_rst), 16'h0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    for (int i = 0; i < NVEC; i++) begin
      logic we, ge;
      logic [7:0] wd, pc, ep, epp;
      logic [4:0] ir, im;
      {we, wd, ir, im, ge, pc, ep, epp} = VECS[i];
      wr_en = we; wr_data = wd; irq_req = ir; irq_en = im; irq_global_en = ge; port_cpu = pc;
      @(posedge clk); @(negedge clk); #1;
      wr_en = 1'b0;
      chk($sformatf("R7 vec%0d pcon", i), 16'(pcon_rd), 16'(ep));
      chk($sformatf("R3 vec%0d port_pins", i), 16'(port_pins), 16'(epp));
      chk($sformatf("R1 vec%0d cpu_clk_en", i), 16'(cpu_clk_en), 16'(!ep[0]));
      chk($sformatf("R4 vec%0d ale/psen", i), 16'({ale, psen}), {14'h0, ep[0], ep[0]});
    end
    irq_req = '0; irq_en = '0; irq_global_en = 1'b0;

    // R4 pass-through outside idle
    ale_cpu = 1'b1; psen_cpu = 1'b0; #2;
    chk("R4 pass-through", 16'({ale, psen}), 16'b10);
    ale_cpu = 1'b0;

    // R1 no gated edge after entry, R2 peripherals clocked
    @(negedge clk); #1;
    wr(8'h09);
    gclk_edges = 0;
    repeat (8) @(negedge clk);
    #1;
    chk("R1 gated edges in idle", 16'(gclk_edges), 16'd0);
    chk("R2 periph_clk_en in idle", 16'(periph_clk_en), 16'h1);
    chk("R7 flags after entry", 16'(pcon_rd), 16'h09);
    irq_req = 5'h08; irq_en = 5'h08; irq_global_en = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R5 gated clock resumes", 16'(gclk_edges > 0), 16'h1);
    chk("R2 periph_clk_en awake", 16'(periph_clk_en), 16'h1);
    irq_req = '0; irq_en = '0; irq_global_en = 1'b0;

    // R9 reset pin for 23 periods is ignored
    wr(8'h0D);
    @(negedge clk); #1;
    rst_pin = 1'b1;
    repeat (23) @(negedge clk);
    #1 rst_pin = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk("R9 no core_rst", 16'(rst_seen), 16'h0);
    chk("R9 pcon kept", 16'(pcon_rd), 16'h0D);
    chk("R9 still gated", 16'(cpu_clk_en), 16'h0);

    // R8 reset pin for 24 periods qualifies
    rst_pin = 1'b1;
    repeat (24) @(negedge clk);
    #1 rst_pin = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk("R8 core_rst seen", 16'(rst_seen), 16'h1);
    chk("R8 pcon cleared", 16'(pcon_rd), 16'h00);
    chk("R8 cpu_clk_en restored", 16'(cpu_clk_en), 16'h1);
    chk("R8 core_rst released", 16'(core_rst), 16'h0);

    // R11 enable never moved during a high phase
    chk("R11 glitches", 16'(glitches), 16'd0);

    finish_run();
  end
endmodule